// File: doc/BRIEF.md
# Resource Assignment Sequencer

This block performs the startup address assignment that boot firmware would otherwise do for the devices on a configuration bus. After a start pulse it visits every slot position in a fixed order. Positions are indexed by a bus number and a device/function number, and it skips any position that reports no device. For each populated slot it reads the device's 16-bit class code and, one region at a time, the size and space type (I/O or memory) of each base address region. It then programs each region's base address through a two-phase configuration access port: it loads an address latch first, then writes one dword to the data window.

Two independent bump allocators supply addresses: one for I/O space and one for memory space. Each allocator rounds its pointer up to a multiple of the region size and then advances past the region. One legacy storage-controller class bypasses the allocators and receives a fixed set of four I/O addresses. After a device's regions are programmed, the sequencer writes the device's command register so that I/O decoding, memory decoding or both are turned on. A done flag reports the end of the scan.

Top module: `rsq_top`

## Requirements
- R1: `done` is low after reset. A `start` pulse taken while idle or done begins a scan and drops `done` on the next cycle. A `start` pulse taken during a scan is ignored. `done` rises when the scan ends and stays high until the next `start`.
- R2: Slots are visited with the bus number running from 0 to NUM_BUS-1 and, within each bus, the device/function number running from 0 to NUM_DEVFN-1. A slot whose `slot_present` is low produces no write.
- R3: Each configuration write has two phases. The first is a latch phase (`wr_sel`=0) whose data is bit 31 set, bits 30..24 zero, the bus number in bits 23..16, the device/function number in bits 15..8 and the register offset in bits 7..0. The second is a data phase (`wr_sel`=1) that carries the value.
- R4: `wr_req` stays high, and `wr_sel` and `wr_data` stay unchanged, until `wr_ack` is seen. Each cycle with `wr_req` and `wr_ack` both high completes exactly one phase.
- R5: When `slot_class` equals 16'h0101, regions 0, 1, 2 and 3 receive 32'h1F0, 32'h3F4, 32'h170 and 32'h374, whatever their size. Regions 4 and above get no write, and neither allocator pointer moves.
- R6: For any other class, a region of size 0 gets no write. A region of nonzero power-of-two size gets the pointer of its space (`region_is_io`=1 selects I/O, 0 selects memory) rounded up to a multiple of the size. That pointer then becomes the assigned address plus the size, with 32-bit arithmetic.
- R7: At every `start` the I/O pointer is reset to IO_START (default 32'h0000C000) and the memory pointer to MEM_START (default 32'hF0000000).
- R8: After its regions, a device that received at least one region write gets one write at offset 8'h04. Its data has bit 0 set if any of its programmed regions was I/O and bit 1 set if any was memory; all other bits are zero. A device with no region write gets no command write.
- R9: Region writes within a device go in ascending region order at offset 8'h10 + 4 x region, and the command write comes after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts a scan |
| done | output | 1 | High once the scan has finished |
| slot_bus | output | 8 | Bus number of the slot being queried |
| slot_devfn | output | 8 | Device/function number of the slot being queried |
| region_sel | output | REG_W | Region index being queried |
| slot_present | input | 1 | The queried slot holds a device |
| slot_class | input | 16 | Class code of the queried device (high byte = base class) |
| region_size | input | 32 | Size of the selected region, 0 if unused |
| region_is_io | input | 1 | Selected region lives in I/O space |
| wr_req | output | 1 | Configuration write phase pending |
| wr_sel | output | 1 | 0 = address latch phase, 1 = data window phase |
| wr_data | output | 32 | Value of the current phase |
| wr_ack | input | 1 | Current phase accepted |

## Verification
On every cycle, the assertions check the write handshake hold, the format of each latch word, the rule that a data phase follows each accepted latch phase, the alignment of allocator results and the legal values of command and legacy writes. They also check that the scan counter wraps correctly and that `done` stays quiet and held. Only the bench scenarios can show the full order of writes across devices, the skipped empty slots, the pointer carry-over between devices and the pointer reset on a second start. They are also the only way to show that a start pulse during a scan does not restart it. For these checks, every write is compared with a sequence computed from the slot table.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam logic [7:0]  CMD_OFFSET      = 8'h04;
  localparam logic [7:0]  BAR_BASE_OFFSET = 8'h10;
  localparam logic [15:0] LEGACY_CLASS    = 16'h0101;
  localparam int unsigned LEGACY_REGIONS  = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SLOT,
    SQ_REGION,
    SQ_REG_WAIT,
    SQ_CMD,
    SQ_CMD_WAIT,
    SQ_NEXT,
    SQ_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    CW_IDLE,
    CW_LATCH,
    CW_DATA
  } cw_state_e;

  // Fixed addresses for the legacy storage class, by region index
  function automatic logic [31:0] legacy_addr(input int unsigned idx);
    case (idx)
      0:       return 32'h0000_01F0;
      1:       return 32'h0000_03F4;
      2:       return 32'h0000_0170;
      3:       return 32'h0000_0374;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // Address latch word: enable, bus, device/function, register offset
  function automatic logic [31:0] latch_word(input logic [7:0] bus,
                                             input logic [7:0] devfn,
                                             input logic [7:0] offset);
    return {1'b1, 7'b0, bus, devfn, offset};
  endfunction

endpackage

// File: rtl/rsq_slot_scan.sv
module rsq_slot_scan #(
  parameter int unsigned NUM_BUS   = 256,
  parameter int unsigned NUM_DEVFN = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  output logic [7:0] bus_o,
  output logic [7:0] devfn_o,
  output logic       last_o
);

  localparam int unsigned BUS_W   = (NUM_BUS   > 1) ? $clog2(NUM_BUS)   : 1;
  localparam int unsigned DEVFN_W = (NUM_DEVFN > 1) ? $clog2(NUM_DEVFN) : 1;
  localparam logic [BUS_W-1:0]   BUS_MAX   = BUS_W'(NUM_BUS - 1);
  localparam logic [DEVFN_W-1:0] DEVFN_MAX = DEVFN_W'(NUM_DEVFN - 1);

  logic [BUS_W-1:0]   bus_q,   bus_d;
  logic [DEVFN_W-1:0] devfn_q, devfn_d;
  logic               cnt_en;

  assign cnt_en = clear | step;

  always_comb begin
    bus_d   = bus_q;
    devfn_d = devfn_q;
    if (clear) begin
      bus_d   = '0;
      devfn_d = '0;
    end else if (step) begin
      if (devfn_q == DEVFN_MAX) begin
        devfn_d = '0;
        bus_d   = bus_q + 1'b1;
      end else begin
        devfn_d = devfn_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      devfn_q <= '0;
    end else if (cnt_en) begin
      bus_q   <= bus_d;
      devfn_q <= devfn_d;
    end
  end

  assign bus_o   = 8'(bus_q);
  assign devfn_o = 8'(devfn_q);
  assign last_o  = (bus_q == BUS_MAX) && (devfn_q == DEVFN_MAX);

  // R2: end of a bus rolls over to device/function 0 of the next bus
  a_r2_devfn_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !last_o && devfn_q == DEVFN_MAX)
      |=> (devfn_q == '0) && (bus_q == BUS_W'($past(bus_q) + 1'b1)));

endmodule

// File: rtl/rsq_bump_alloc.sv
module rsq_bump_alloc #(
  parameter logic [31:0] START = 32'h0000_C000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        take,
  input  logic [31:0] size_i,
  output logic [31:0] addr_o
);

  logic [31:0] ptr_q, ptr_d;
  logic [31:0] size_mask;
  logic        ptr_en;

  assign size_mask = size_i - 32'd1;
  assign addr_o    = (ptr_q + size_mask) & ~size_mask;
  assign ptr_en    = init | take;

  always_comb begin
    ptr_d = ptr_q;
    if (init) begin
      ptr_d = START;
    end else if (take) begin
      ptr_d = addr_o + size_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= START;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // R6: a power-of-two region is handed an address that is a multiple of its size
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $countones(size_i) == 1) |-> ((addr_o % size_i) == 32'd0));

endmodule

// File: rtl/rsq_cfg_writer.sv
module rsq_cfg_writer
  import rsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] latch_i,
  input  logic [31:0] data_i,
  output logic        finish,
  output logic        wr_req,
  output logic        wr_sel,
  output logic [31:0] wr_data,
  input  logic        wr_ack
);

  cw_state_e   state_q, state_d;
  logic [31:0] latch_q, data_q;
  logic        capture;

  assign capture = (state_q == CW_IDLE) && go;

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    case (state_q)
      CW_IDLE:  if (go)     state_d = CW_LATCH;
      CW_LATCH: if (wr_ack) state_d = CW_DATA;
      CW_DATA: begin
        if (wr_ack) begin
          state_d = CW_IDLE;
          finish  = 1'b1;
        end
      end
      default:  state_d = CW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      data_q  <= '0;
    end else if (capture) begin
      latch_q <= latch_i;
      data_q  <= data_i;
    end
  end

  assign wr_req  = (state_q != CW_IDLE);
  assign wr_sel  = (state_q == CW_DATA);
  assign wr_data = wr_sel ? data_q : latch_q;

  // R4: a pending phase holds until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_sel) && $stable(wr_data)));

  // R3: latch phase word carries the enable bit and a dword-aligned offset
  a_r3_latch_format: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_sel) |-> (wr_data[31] && wr_data[30:24] == 7'd0 && wr_data[1:0] == 2'd0));

  // R3: an accepted latch phase is followed by a data phase
  a_r3_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_sel && wr_ack) |=> (wr_req && wr_sel));

endmodule

// File: rtl/rsq_top.sv
module rsq_top
  import rsq_pkg::*;
#(
  parameter int unsigned NUM_BUS     = 256,
  parameter int unsigned NUM_DEVFN   = 256,
  parameter int unsigned NUM_REGIONS = 6,
  parameter logic [31:0] IO_START    = 32'h0000_C000,
  parameter logic [31:0] MEM_START   = 32'hF000_0000,
  localparam int unsigned REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic [7:0]       slot_bus,
  output logic [7:0]       slot_devfn,
  output logic [REG_W-1:0] region_sel,
  input  logic             slot_present,
  input  logic [15:0]      slot_class,
  input  logic [31:0]      region_size,
  input  logic             region_is_io,
  output logic             wr_req,
  output logic             wr_sel,
  output logic [31:0]      wr_data,
  input  logic             wr_ack
);

  localparam logic [REG_W-1:0] REG_MAX = REG_W'(NUM_REGIONS - 1);

  seq_state_e       state_q, state_d;
  logic [REG_W-1:0] region_q, region_d;
  logic             io_en_q, io_en_d;
  logic             mem_en_q, mem_en_d;

  logic             scan_clear, scan_step, scan_last;
  logic             alloc_init, io_take, mem_take;
  logic [31:0]      io_addr, mem_addr;
  logic             wr_go, wr_finish;
  logic [31:0]      go_latch, go_data;
  logic             cls_legacy, region_last, legacy_slot_hit;
  logic [7:0]       bar_off;

  assign cls_legacy      = (slot_class == LEGACY_CLASS);
  assign region_last     = (region_q == REG_MAX);
  assign legacy_slot_hit = (int'(region_q) < LEGACY_REGIONS);
  assign bar_off         = BAR_BASE_OFFSET + 8'({region_q, 2'b00});

  rsq_slot_scan #(
    .NUM_BUS   (NUM_BUS),
    .NUM_DEVFN (NUM_DEVFN)
  ) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (scan_clear),
    .step    (scan_step),
    .bus_o   (slot_bus),
    .devfn_o (slot_devfn),
    .last_o  (scan_last)
  );

  rsq_bump_alloc #(.START(IO_START)) u_io_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (alloc_init),
    .take   (io_take),
    .size_i (region_size),
    .addr_o (io_addr)
  );

  rsq_bump_alloc #(.START(MEM_START)) u_mem_alloc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (alloc_init),
    .take   (mem_take),
    .size_i (region_size),
    .addr_o (mem_addr)
  );

  rsq_cfg_writer u_writer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (wr_go),
    .latch_i (go_latch),
    .data_i  (go_data),
    .finish  (wr_finish),
    .wr_req  (wr_req),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .wr_ack  (wr_ack)
  );

  always_comb begin
    state_d    = state_q;
    region_d   = region_q;
    io_en_d    = io_en_q;
    mem_en_d   = mem_en_q;
    scan_clear = 1'b0;
    scan_step  = 1'b0;
    alloc_init = 1'b0;
    io_take    = 1'b0;
    mem_take   = 1'b0;
    wr_go      = 1'b0;
    go_latch   = '0;
    go_data    = '0;
    case (state_q)
      SQ_IDLE, SQ_DONE: begin
        if (start) begin
          scan_clear = 1'b1;
          alloc_init = 1'b1;
          state_d    = SQ_SLOT;
        end
      end
      SQ_SLOT: begin
        region_d = '0;
        io_en_d  = 1'b0;
        mem_en_d = 1'b0;
        state_d  = slot_present ? SQ_REGION : SQ_NEXT;
      end
      SQ_REGION: begin
        go_latch = latch_word(slot_bus, slot_devfn, bar_off);
        if (cls_legacy) begin
          wr_go   = legacy_slot_hit;
          go_data = legacy_addr(int'(region_q));
        end else begin
          wr_go    = (region_size != 32'd0);
          io_take  = wr_go && region_is_io;
          mem_take = wr_go && !region_is_io;
          go_data  = region_is_io ? io_addr : mem_addr;
        end
        if (wr_go) begin
          io_en_d  = io_en_q | region_is_io;
          mem_en_d = mem_en_q | !region_is_io;
          state_d  = SQ_REG_WAIT;
        end else if (region_last) begin
          state_d = SQ_CMD;
        end else begin
          region_d = region_q + 1'b1;
        end
      end
      SQ_REG_WAIT: begin
        if (wr_finish) begin
          if (region_last) begin
            state_d = SQ_CMD;
          end else begin
            region_d = region_q + 1'b1;
            state_d  = SQ_REGION;
          end
        end
      end
      SQ_CMD: begin
        if (io_en_q || mem_en_q) begin
          wr_go    = 1'b1;
          go_latch = latch_word(slot_bus, slot_devfn, CMD_OFFSET);
          go_data  = {30'd0, mem_en_q, io_en_q};
          state_d  = SQ_CMD_WAIT;
        end else begin
          state_d = SQ_NEXT;
        end
      end
      SQ_CMD_WAIT: begin
        if (wr_finish) state_d = SQ_NEXT;
      end
      SQ_NEXT: begin
        if (scan_last) begin
          state_d = SQ_DONE;
        end else begin
          scan_step = 1'b1;
          state_d   = SQ_SLOT;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      region_q <= '0;
      io_en_q  <= 1'b0;
      mem_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      region_q <= region_d;
      io_en_q  <= io_en_d;
      mem_en_q <= mem_en_d;
    end
  end

  assign done       = (state_q == SQ_DONE);
  assign region_sel = region_q;

  // R1: no configuration traffic once the scan has finished
  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_req);

  // R1: done holds until a new start
  a_r1_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8: command data carries only the two decode enables, at least one set
  a_r8_cmd_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_sel && state_q == SQ_CMD_WAIT)
      |-> (wr_data[31:2] == 30'd0 && wr_data[1:0] != 2'd0));

  // R5: legacy-class region data is one of the fixed addresses
  a_r5_legacy_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_sel && state_q == SQ_REG_WAIT && cls_legacy)
      |-> (wr_data == 32'h1F0 || wr_data == 32'h3F4 ||
           wr_data == 32'h170 || wr_data == 32'h374));

endmodule

// File: tb/rsq_top_tb_top.sv
module rsq_top_tb_top;

  localparam int NB = 3;
  localparam int ND = 16;
  localparam int NR = 6;
  localparam int NS = NB * ND;
  localparam int EXP_MAX = 1024;
  localparam logic [31:0] IO_START  = 32'h0000_C000;
  localparam logic [31:0] MEM_START = 32'hF000_0000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        done;
  logic [7:0]  slot_bus, slot_devfn;
  logic [2:0]  region_sel;
  logic        slot_present;
  logic [15:0] slot_class;
  logic [31:0] region_size;
  logic        region_is_io;
  logic        wr_req, wr_sel;
  logic [31:0] wr_data;
  logic        wr_ack;

  rsq_top #(
    .NUM_BUS     (NB),
    .NUM_DEVFN   (ND),
    .NUM_REGIONS (NR),
    .IO_START    (IO_START),
    .MEM_START   (MEM_START)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .slot_bus     (slot_bus),
    .slot_devfn   (slot_devfn),
    .region_sel   (region_sel),
    .slot_present (slot_present),
    .slot_class   (slot_class),
    .region_size  (region_size),
    .region_is_io (region_is_io),
    .wr_req       (wr_req),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .wr_ack       (wr_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Slot table
  logic        pres [NS];
  logic [15:0] cls  [NS];
  logic [31:0] sz   [NS][NR];
  logic        isio [NS][NR];

  always_comb begin
    int s;
    s = int'(slot_bus) * ND + int'(slot_devfn);
    slot_present = 1'b0;
    slot_class   = 16'h0;
    region_size  = 32'h0;
    region_is_io = 1'b0;
    if (s < NS && int'(region_sel) < NR) begin
      slot_present = pres[s];
      slot_class   = cls[s];
      region_size  = sz[s][region_sel];
      region_is_io = isio[s][region_sel];
    end
  end

  // Expected write sequence
  logic  [31:0] exp_val [EXP_MAX];
  logic         exp_sel [EXP_MAX];
  string        exp_tag [EXP_MAX];
  int           exp_n;
  int           obs_n;
  int           chk_n;
  int           fail_n;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic push(input logic sel, input logic [31:0] v, input string tag);
    if (exp_n < EXP_MAX) begin
      exp_sel[exp_n] = sel;
      exp_val[exp_n] = v;
      exp_tag[exp_n] = tag;
    end
    exp_n++;
  endtask

  function automatic logic [31:0] fixed_addr(input int r);
    case (r)
      0: return 32'h1F0;
      1: return 32'h3F4;
      2: return 32'h170;
      default: return 32'h374;
    endcase
  endfunction

  function automatic logic [31:0] latch_of(input int b, input int d, input int off);
    return 32'h8000_0000 | (32'(b) << 16) | (32'(d) << 8) | 32'(off);
  endfunction

  task automatic build_expect();
    logic [31:0] iop, memp, a;
    iop   = IO_START;     // R7: pointers restart at every scan
    memp  = MEM_START;
    exp_n = 0;
    for (int b = 0; b < NB; b++) begin
      for (int d = 0; d < ND; d++) begin
        int  s;
        bit  ioe, meme;
        s    = b * ND + d;
        ioe  = 1'b0;
        meme = 1'b0;
        if (pres[s]) begin
          for (int r = 0; r < NR; r++) begin
            bit    hit;
            string dtag;
            hit = 1'b0;
            a   = 32'h0;
            dtag = "R6 R7";
            if (cls[s] == 16'h0101) begin
              if (r < 4) begin
                hit  = 1'b1;
                a    = fixed_addr(r);
                dtag = "R5";
              end
            end else if (sz[s][r] != 0) begin
              hit = 1'b1;
              if (isio[s][r]) begin
                a   = (iop + sz[s][r] - 1) & ~(sz[s][r] - 1);
                iop = a + sz[s][r];
              end else begin
                a    = (memp + sz[s][r] - 1) & ~(sz[s][r] - 1);
                memp = a + sz[s][r];
              end
            end
            if (hit) begin
              push(1'b0, latch_of(b, d, 16 + 4 * r), "R3 R9");
              push(1'b1, a, dtag);
              if (isio[s][r]) ioe = 1'b1;
              else            meme = 1'b1;
            end
          end
          if (ioe || meme) begin
            push(1'b0, latch_of(b, d, 4), "R8 R9");
            push(1'b1, {30'd0, meme, ioe}, "R8");
          end
        end
      end
    end
  endtask

  // Write responder and monitor: random acknowledge delay
  bit          phase_open;
  logic        first_sel;
  logic [31:0] first_data;
  int          wait_left;

  initial begin
    wr_ack     = 1'b0;
    phase_open = 1'b0;
    wait_left  = 0;
    obs_n      = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        wr_ack     = 1'b0;
        phase_open = 1'b0;
      end else if (wr_ack) begin
        wr_ack = 1'b0;
      end else if (wr_req) begin
        if (!phase_open) begin
          phase_open = 1'b1;
          first_sel  = wr_sel;
          first_data = wr_data;
          wait_left  = int'($urandom_range(0, 3));
        end
        if (wait_left == 0) begin
          // R4: the phase value is unchanged from first sight to acceptance
          check(wr_sel == first_sel && wr_data == first_data, "R4", wr_data, first_data);
          if (obs_n < exp_n && obs_n < EXP_MAX) begin
            check(wr_sel == exp_sel[obs_n] && wr_data == exp_val[obs_n],
                  exp_tag[obs_n], wr_data, exp_val[obs_n]);
          end else begin
            check(1'b0, "R2 extra write", wr_data, 32'h0);
          end
          obs_n++;
          wr_ack     = 1'b1;
          phase_open = 1'b0;
        end else begin
          wait_left--;
        end
      end
    end
  end

  task automatic clear_table();
    for (int s = 0; s < NS; s++) begin
      pres[s] = 1'b0;
      cls[s]  = 16'h0200;
      for (int r = 0; r < NR; r++) begin
        sz[s][r]   = 32'h0;
        isio[s][r] = 1'b0;
      end
    end
  endtask

  task automatic random_table();
    for (int s = 0; s < NS; s++) begin
      pres[s] = ($urandom_range(0, 9) < 4);
      cls[s]  = ($urandom_range(0, 5) == 0) ? 16'h0101 : 16'($urandom_range(0, 16'hFFFF));
      for (int r = 0; r < NR; r++) begin
        isio[s][r] = $urandom_range(0, 1) == 1;
        if ($urandom_range(0, 1) == 0) sz[s][r] = 32'h0;
        else if (isio[s][r])           sz[s][r] = 32'h1 << $urandom_range(2, 12);
        else                           sz[s][r] = 32'h1 << $urandom_range(4, 20);
      end
    end
  endtask

  bit wd_expired;

  // Runs one scan; optional start pulse mid-scan must be ignored (R1)
  task automatic run_scan(input bit poke_busy);
    int cyc;
    build_expect();
    obs_n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R1 done drops after start", 32'(done), 32'd0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_busy && cyc == 30 && !done) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc++;
      end
    end
    if (!done) begin
      wd_expired = 1'b1;
      check(1'b0, "R1 watchdog expired", 32'(cyc), 32'd20000);
    end
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 done held", 32'(done), 32'd1);
    check(obs_n == exp_n, "R2 write count", 32'(obs_n), 32'(exp_n));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    chk_n      = 0;
    fail_n     = 0;
    exp_n      = 0;
    wd_expired = 1'b0;
    start      = 1'b0;
    rst_n      = 1'b0;
    clear_table();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
    check(wr_req == 1'b0, "R1 reset wr_req", 32'(wr_req), 32'd0);

    // R2: empty population, no writes
    run_scan(1'b0);

    // Directed corners
    clear_table();
    pres[0] = 1'b1; cls[0] = 16'h0101;                 // R5 legacy at bus 0 devfn 0
    sz[0][0] = 32'h8; isio[0][0] = 1'b1;
    sz[0][1] = 32'h0; isio[0][1] = 1'b1;               // legacy writes even size 0
    sz[0][4] = 32'h100; isio[0][4] = 1'b0;             // region 4 ignored for legacy
    sz[0][2] = 32'h8; isio[0][2] = 1'b1;
    sz[0][3] = 32'h4; isio[0][3] = 1'b1;
    pres[3] = 1'b1; cls[3] = 16'h0C03;                 // R6 alignment corner
    sz[3][0] = 32'h1_0000; isio[3][0] = 1'b1;          // 0xC000 rounds to 0x10000
    sz[3][1] = 32'h100;    isio[3][1] = 1'b0;
    sz[3][3] = 32'h4;      isio[3][3] = 1'b1;
    sz[3][5] = 32'h100_0000; isio[3][5] = 1'b0;        // memory jumps to next 16M
    pres[ND + 5] = 1'b1; cls[ND + 5] = 16'h0300;       // R8: no regions, no command write
    pres[NS - 1] = 1'b1; cls[NS - 1] = 16'h0200;       // last slot of the scan
    sz[NS - 1][2] = 32'h20; isio[NS - 1][2] = 1'b1;
    run_scan(1'b0);
    // R7: same table again from fresh pointers
    run_scan(1'b0);

    // Constrained random populations, one with a start during the scan
    for (int k = 0; k < 4; k++) begin
      random_table();
      run_scan(k == 1);
    end

    if (wd_expired) $display("watchdog expired during run");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  end

endmodule